// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block produces the oversampling tick for a serial receiver and transmitter from a fast system clock. It does not count a divisor down. A 16-bit step value is added to a 16-bit phase register on every enabled clock, and the carry out of that sum becomes the oversample tick. The tick rate is therefore proportional to the step: tick rate = f_clk × step / 2^16. The bit rate is one sixteenth of that: baud = f_clk × step / 2^20. At 100 MHz the programmed step is baud × 2^20 / 10^8, rounded to an integer. The largest step gives a bit rate just below f_clk / 16.

The step comes in as two bytes, which a register file elsewhere holds. A divide-by-16 counter of ticks gives a bit-period strobe, which the framing logic uses. When the enable input is low, the phase and the tick counter are held at zero. Each enabled run therefore starts from a known phase.

Top module: `baud_tick_gen`

## Requirements
- R1: The step is {step_hi, step_lo}, with step_hi as the upper byte. Over the first N enabled cycles after the enable rises from a cleared state, the number of oversample ticks is exactly floor(N × step / 65536).
- R2: The tick is registered and lasts one clock per carry. From a cleared state with step 0x8000, the first edge with enable high gives no tick and the second edge gives one.
- R3: On a clock edge with enable low, the phase register and the tick counter clear. The tick and bit strobe are low after that edge.
- R4: A step of zero produces no tick.
- R5: The bit strobe rises together with every 16th tick counted from enable, so in N enabled cycles it pulses floor(ticks / 16) times. It is never high without a tick, and never high on two consecutive cycles.
- R6: With step 0xFFFF, starting from a cleared state, every enabled cycle except the first carries a tick. This is the highest rate, a bit rate just below f_clk / 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low clears phase and tick counter |
| step_hi | input | 8 | Upper byte of the phase step |
| step_lo | input | 8 | Lower byte of the phase step |
| os_tick | output | 1 | One-cycle oversample tick (carry of the phase add) |
| bit_stb | output | 1 | One-cycle bit-period strobe, every 16th tick |

## Verification
The oversample tick and the bit-period strobe fall in the same cycle on every sixteenth carry. Runs with several steps check the tick total and the strobe total over a fixed window against floor arithmetic. The strobe is checked never to appear without its tick. A second collision arises when the enable drops in a cycle whose add would carry. The bench sets up a phase that is about to carry, clears it, and then confirms that the following run starts from phase zero by timing its first tick.

// File: rtl/baud_pkg.sv
package baud_pkg;
   localparam int unsigned BAUD_BYTE_W   = 8;
   localparam int unsigned BAUD_OVS      = 16;

   typedef struct packed {
      logic tick;
      logic stb;
   } baud_evt_t;
endpackage

// File: rtl/baud_step_join.sv
module baud_step_join #(
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned STEP_W = 2 * BYTE_W
) (
   input  logic [BYTE_W-1:0] hi_i,
   input  logic [BYTE_W-1:0] lo_i,
   output logic [STEP_W-1:0] step_o
);
   if (BYTE_W < 1) begin : g_bad_w
      $error("baud_step_join: BYTE_W must be positive");
   end

   assign step_o = {hi_i, lo_i};
endmodule

// File: rtl/baud_phase_acc.sv
module baud_phase_acc #(
   parameter int unsigned ACC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [ACC_W-1:0] step_i,
   output logic             carry_o
);
   if (ACC_W < 2) begin : g_bad_w
      $error("baud_phase_acc: ACC_W must be at least 2");
   end

   logic [ACC_W-1:0] phase_q;
   logic [ACC_W:0]   sum;

   assign sum = {1'b0, phase_q} + {1'b0, step_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         carry_o <= 1'b0;
      end else if (!en_i) begin
         phase_q <= '0;
         carry_o <= 1'b0;
      end else begin
         phase_q <= sum[ACC_W-1:0];
         carry_o <= sum[ACC_W];
      end
   end
endmodule

// File: rtl/baud_ovs_div.sv
module baud_ovs_div #(
   parameter int unsigned OVS = 16,
   localparam int unsigned CNT_W = (OVS > 1) ? $clog2(OVS) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic tick_i,
   output logic stb_o
);
   if (OVS < 1 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
      $error("baud_ovs_div: OVS must be a power of two");
   end

   if (OVS == 1) begin : g_pass
      assign stb_o = tick_i;
   end else begin : g_count
      localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (!en_i) begin
            cnt_q <= '0;
         end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign stb_o = tick_i && (cnt_q == LAST);
   end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
   import baud_pkg::*;
#(
   parameter int unsigned BYTE_W = BAUD_BYTE_W,
   parameter int unsigned OVS    = BAUD_OVS,
   localparam int unsigned ACC_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [BYTE_W-1:0] step_hi,
   input  logic [BYTE_W-1:0] step_lo,
   output logic              os_tick,
   output logic              bit_stb
);
   logic [ACC_W-1:0] step;
   baud_evt_t        evt;

   baud_step_join #(.BYTE_W(BYTE_W)) u_join (
      .hi_i  (step_hi),
      .lo_i  (step_lo),
      .step_o(step)
   );

   baud_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (en),
      .step_i (step),
      .carry_o(evt.tick)
   );

   baud_ovs_div #(.OVS(OVS)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (en),
      .tick_i(evt.tick),
      .stb_o (evt.stb)
   );

   assign os_tick = evt.tick;
   assign bit_stb = evt.stb;
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
   parameter int unsigned BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic [BYTE_W-1:0] step_hi,
   input logic [BYTE_W-1:0] step_lo,
   input logic              os_tick,
   input logic              bit_stb
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!os_tick && !bit_stb)); // R3

   AST_ZERO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step_hi == '0 && step_lo == '0) |=> !os_tick); // R4

   AST_STB_WITH_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb |-> os_tick); // R5

   AST_STB_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb |=> !bit_stb); // R5

   AST_FULL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && os_tick && step_hi == '1 && step_lo == '1) |=> os_tick); // R6
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .en     (en),
   .step_hi(step_hi),
   .step_lo(step_lo),
   .os_tick(os_tick),
   .bit_stb(bit_stb)
);

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [7:0] step_hi = '0;
   logic [7:0] step_lo = '0;
   logic       os_tick;
   logic       bit_stb;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   baud_tick_gen u_baud_tick_gen (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .step_hi(step_hi),
      .step_lo(step_lo),
      .os_tick(os_tick),
      .bit_stb(bit_stb)
   );

   localparam int NVEC = 6;
   localparam logic [15:0] V_STEP [NVEC] = '{16'h8000, 16'hFFFF, 16'h0100, 16'h1234, 16'h0000, 16'h3412};
   localparam int          V_CYC  [NVEC] = '{64, 100, 4096, 1000, 200, 700};

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   task automatic run(input logic [15:0] s, input int n, output int nt, output int ns);
      @(negedge clk);
      en = 1'b0;
      {step_hi, step_lo} = s;
      @(negedge clk);
      en = 1'b1;
      nt = 0;
      ns = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         nt += int'(os_tick);
         ns += int'(bit_stb);
      end
      en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

   initial begin
      int nt, ns;
      longint et;
      repeat (3) @(negedge clk);
      check("R3 reset tick", os_tick, 0);
      check("R3 reset strobe", bit_stb, 0);
      rst_n = 1'b1;

      // table walk: R1 totals, R4 zero step, R5 strobe totals, R6 full step
      for (int v = 0; v < NVEC; v++) begin
         run(V_STEP[v], V_CYC[v], nt, ns);
         et = (longint'(V_CYC[v]) * longint'(V_STEP[v])) >> 16;
         check(V_STEP[v] == 0 ? "R4 zero step ticks" :
               (V_STEP[v] == 16'hFFFF ? "R6 full step ticks" : "R1 tick total"), nt, et);
         check("R5 strobe total", ns, et / 16);
      end

      // R2: first tick on the second edge with half step
      @(negedge clk);
      {step_hi, step_lo} = 16'h8000;
      en = 1'b1;
      @(negedge clk);
      check("R2 no tick first edge", os_tick, 0);
      @(negedge clk);
      check("R2 tick second edge", os_tick, 1);
      @(negedge clk);
      check("R2 tick one cycle wide", os_tick, 0);

      // R3: phase 0xC000 pending, then enable dropped; phase must restart at zero
      en = 1'b0;
      @(negedge clk);
      {step_hi, step_lo} = 16'hC000;
      en = 1'b1;
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      check("R3 tick low after disable", os_tick, 0);
      check("R3 strobe low after disable", bit_stb, 0);
      {step_hi, step_lo} = 16'h8000;
      en = 1'b1;
      @(negedge clk);
      check("R3 phase cleared (no early carry)", os_tick, 0);

      // R6: full step ticks on every cycle after the first
      en = 1'b0;
      @(negedge clk);
      {step_hi, step_lo} = 16'hFFFF;
      en = 1'b1;
      @(negedge clk);
      check("R6 first cycle no tick", os_tick, 0);
      nt = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         nt += int'(os_tick);
      end
      check("R6 continuous ticks", nt, 40);
      en = 1'b0;

      // R1 byte order: 0x0001 vs 0x0100 over 256 cycles
      run(16'h0001, 256, nt, ns);
      check("R1 low byte weight", nt, 0);
      run(16'h0100, 256, nt, ns);
      check("R1 high byte weight", nt, 1);

      done = 1'b1;
      report();
   end
endmodule